// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block prepares the second operand of a 32-bit integer datapath. It takes a source value, a two-bit shift kind and a shift amount. The amount comes either from a five-bit field of the instruction or from the low byte of a register value. The block returns the shifted value together with the carry produced by the shift. A zero amount does not always mean "no shift". Each shift kind gives it its own meaning, and a zero rotate from the instruction field becomes a one-bit rotate through the incoming carry.

A second mode builds a constant operand. An eight-bit constant is rotated right by twice a four-bit rotate field. The result and the carry are registered once, so both appear on the outputs one clock after the inputs are presented. The flag register, the ALU and the register file stay outside the block. The caller supplies the current carry and consumes the carry-out.

Top module: `opsh_top`

## Requirements
- R1: Shift kind is encoded 0 = shift left logical, 1 = shift right logical, 2 = shift right arithmetic, 3 = rotate right. For shift left with an amount n of 1 to 31, the result is the source shifted left by n and the carry is source bit 32−n.
- R2: For shift right logical or arithmetic with n of 1 to 31, the result is the shifted source and the carry is source bit n−1. The arithmetic shift fills with source bit 31.
- R3: Rotate right with a nonzero amount rotates by n modulo 32, and the carry equals result bit 31. When n is a nonzero multiple of 32, the value is unchanged and the carry is source bit 31.
- R4: With a zero amount, shift left and arithmetic right return the source unchanged, and the carry equals carry_in.
- R5: With a zero amount, logical right returns the source unchanged, and the carry equals source bit 31.
- R6: A rotate with a zero amount taken from the instruction field (amt_from_reg = 0) rotates right by one through the carry. The carry becomes source bit 0, and carry_in enters at bit 31.
- R7: A rotate with a zero amount taken from a register (amt_from_reg = 1) returns the source unchanged, and the carry equals carry_in.
- R8: Arithmetic right by 32 or more yields all ones or all zeros according to source bit 31, and the carry equals source bit 31.
- R9: A logical shift by exactly 32 yields zero, with carry source bit 0 for left and source bit 31 for right. A logical shift by more than 32 yields zero with carry 0.
- R10: A register-sourced amount uses only reg_amt bits 7:0, and bits 31:8 have no effect. When amt_from_reg = 0, the amount is imm_amt and reg_amt is ignored.
- R11: With imm_mode = 1, the result is imm8 zero-extended and rotated right by 2·rot4, and shift_kind and the amount inputs are ignored. The carry is carry_in when rot4 = 0 and result bit 31 otherwise.
- R12: The outputs are registered with one clock of latency. A synchronous active-low reset clears shifted_out and carry_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imm_mode | input | 1 | 1 selects constant expansion from imm8/rot4 |
| src_val | input | 32 | Value to shift |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| amt_from_reg | input | 1 | 1: amount from reg_amt, 0: from imm_amt |
| imm_amt | input | 5 | Instruction-field shift amount |
| reg_amt | input | 32 | Register value supplying the amount (low byte used) |
| carry_in | input | 1 | Current carry flag |
| imm8 | input | 8 | Constant for imm_mode |
| rot4 | input | 4 | Rotate field for imm_mode (rotation 2·rot4) |
| shifted_out | output | 32 | Registered shifted operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
Each shift kind is tried with amounts of 0, 1, 31, 32 and 33, and with register amounts whose upper bytes are nonzero. This separates the zero-amount rules of each kind, the bit-32 boundary and the low-byte truncation. Sources with bit 31 set and clear, combined with both carry_in values, tell a pass-through carry from a source-bit carry and from an arithmetic fill. Constant mode is exercised with rot4 at zero and nonzero under conflicting shift inputs. A long run of random vectors is then compared each clock against a model that shifts one bit per step.

// File: rtl/opsh_pkg.sv
// Package: shared encodings for the operand shifter.
// Assumes the shift kind is a two-bit field decoded directly by the datapath.
package opsh_pkg;
    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;
endpackage

// File: rtl/opsh_amount_sel.sv
// Module: picks the shift amount from the instruction field or the low byte
// of a register value, and flags a zero amount.
// Assumes REG_AMT_W >= IMM_AMT_W and DATA_W >= REG_AMT_W.
module opsh_amount_sel #(
    parameter int DATA_W    = 32,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8
) (
    input  logic                 amt_from_reg,
    input  logic [IMM_AMT_W-1:0] imm_amt,
    input  logic [DATA_W-1:0]    reg_amt,
    output logic [REG_AMT_W-1:0] amt,
    output logic                 amt_zero
);
    // Select and zero-extend the amount source.
    always_comb begin
        if (amt_from_reg) amt = reg_amt[REG_AMT_W-1:0];
        else              amt = REG_AMT_W'(imm_amt);
        amt_zero = (amt == '0);
    end
endmodule

// File: rtl/opsh_barrel.sv
// Module: barrel shift for a nonzero amount with carry-out.
// Assumes amt != 0; the zero-amount rules are applied by the caller.
// Each shift is done on a value widened by one bit so the carry falls out
// of the extra bit position.
module opsh_barrel
    import opsh_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8
) (
    input  logic [DATA_W-1:0]    val,
    input  shift_kind_e          kind,
    input  logic [REG_AMT_W-1:0] amt,
    output logic [DATA_W-1:0]    res,
    output logic                 cout
);
    localparam int ROT_AMT_W = $clog2(DATA_W);

    logic [DATA_W:0]          lsl_ext;
    logic [DATA_W:0]          lsr_ext;
    logic signed [DATA_W:0]   asr_ext;
    logic [REG_AMT_W-1:0]     asr_amt;
    logic [2*DATA_W-1:0]      ror_dbl;

    // Compute all four shift variants in parallel.
    always_comb begin
        lsl_ext = {1'b0, val} << amt;
        lsr_ext = {val, 1'b0} >> amt;
        asr_amt = (amt > REG_AMT_W'(DATA_W)) ? REG_AMT_W'(DATA_W) : amt;
        asr_ext = $signed({val, 1'b0}) >>> asr_amt;
        ror_dbl = {val, val} >> amt[ROT_AMT_W-1:0];
    end

    // Choose the variant and its carry by shift kind.
    always_comb begin
        unique case (kind)
            SK_LSL: begin
                res  = lsl_ext[DATA_W-1:0];
                cout = lsl_ext[DATA_W];
            end
            SK_LSR: begin
                res  = lsr_ext[DATA_W:1];
                cout = lsr_ext[0];
            end
            SK_ASR: begin
                res  = asr_ext[DATA_W:1];
                cout = asr_ext[0];
            end
            default: begin
                res  = ror_dbl[DATA_W-1:0];
                cout = ror_dbl[DATA_W-1];
            end
        endcase
    end
endmodule

// File: rtl/opsh_imm_expand.sv
// Module: expands a small constant by rotating it right by twice a rotate
// field. Carry passes through for a zero rotate, else is result bit MSB.
module opsh_imm_expand #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0] imm8,
    input  logic [ROT_W-1:0] rot4,
    input  logic             cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    logic [DATA_W-1:0]   ext;
    logic [2*DATA_W-1:0] dbl;

    // Zero-extend, rotate by 2*rot4, derive carry.
    always_comb begin
        ext  = DATA_W'(imm8);
        dbl  = {ext, ext} >> {rot4, 1'b0};
        res  = dbl[DATA_W-1:0];
        cout = (rot4 == '0) ? cin : dbl[DATA_W-1];
    end
endmodule

// File: rtl/opsh_top.sv
// Module: operand shifter top. Applies the zero-amount rules per shift kind,
// otherwise uses the barrel result; constant mode bypasses both. Result and
// carry are registered once. Synchronous active-low reset clears outputs.
module opsh_top
    import opsh_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_AMT_W = $clog2(DATA_W),
    parameter int REG_AMT_W = 8,
    parameter int IMM_W     = 8,
    parameter int ROT_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 imm_mode,
    input  logic [DATA_W-1:0]    src_val,
    input  logic [1:0]           shift_kind,
    input  logic                 amt_from_reg,
    input  logic [IMM_AMT_W-1:0] imm_amt,
    input  logic [DATA_W-1:0]    reg_amt,
    input  logic                 carry_in,
    input  logic [IMM_W-1:0]     imm8,
    input  logic [ROT_W-1:0]     rot4,
    output logic [DATA_W-1:0]    shifted_out,
    output logic                 carry_out
);
    localparam int MSB = DATA_W - 1;

    shift_kind_e          kind;
    logic [REG_AMT_W-1:0] amt;
    logic                 amt_zero;
    logic [DATA_W-1:0]    bar_res;
    logic                 bar_cout;
    logic [DATA_W-1:0]    imm_res;
    logic                 imm_cout;
    logic [DATA_W-1:0]    nxt_res;
    logic                 nxt_cout;

    assign kind = shift_kind_e'(shift_kind);

    opsh_amount_sel #(
        .DATA_W(DATA_W), .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W)
    ) amt_i (
        .amt_from_reg(amt_from_reg),
        .imm_amt     (imm_amt),
        .reg_amt     (reg_amt),
        .amt         (amt),
        .amt_zero    (amt_zero)
    );

    opsh_barrel #(
        .DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)
    ) bar_i (
        .val (src_val),
        .kind(kind),
        .amt (amt),
        .res (bar_res),
        .cout(bar_cout)
    );

    opsh_imm_expand #(
        .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
    ) imx_i (
        .imm8(imm8),
        .rot4(rot4),
        .cin (carry_in),
        .res (imm_res),
        .cout(imm_cout)
    );

    // Select constant, zero-amount special case, or barrel result.
    always_comb begin
        nxt_res  = bar_res;
        nxt_cout = bar_cout;
        if (imm_mode) begin
            nxt_res  = imm_res;
            nxt_cout = imm_cout;
        end else if (amt_zero) begin
            unique case (kind)
                SK_LSL, SK_ASR: begin
                    nxt_res  = src_val;
                    nxt_cout = carry_in;
                end
                SK_LSR: begin
                    nxt_res  = src_val;
                    nxt_cout = src_val[MSB];
                end
                default: begin
                    if (amt_from_reg) begin
                        nxt_res  = src_val;
                        nxt_cout = carry_in;
                    end else begin
                        nxt_res  = {carry_in, src_val[MSB:1]};
                        nxt_cout = src_val[0];
                    end
                end
            endcase
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shifted_out <= '0;
            carry_out   <= 1'b0;
        end else begin
            shifted_out <= nxt_res;
            carry_out   <= nxt_cout;
        end
    end
endmodule

// File: rtl/opsh_checker.sv
// Module: temporal checks on the operand shifter ports, bound to opsh_top.
// Each property relates inputs of one cycle to registered outputs of the next.
module opsh_checker #(
    parameter int DATA_W    = 32,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 imm_mode,
    input logic [DATA_W-1:0]    src_val,
    input logic [1:0]           shift_kind,
    input logic                 amt_from_reg,
    input logic [IMM_AMT_W-1:0] imm_amt,
    input logic [DATA_W-1:0]    reg_amt,
    input logic                 carry_in,
    input logic [DATA_W-1:0]    shifted_out,
    input logic                 carry_out
);
    localparam int MSB = DATA_W - 1;
    localparam int RW  = IMM_AMT_W;

    logic                 zero_amt;
    logic [REG_AMT_W-1:0] ramt;

    // Recompute the zero-amount condition from the ports.
    always_comb begin
        ramt     = reg_amt[REG_AMT_W-1:0];
        zero_amt = amt_from_reg ? (ramt == '0) : (imm_amt == '0);
    end

    // R4: zero-amount shift left is a pass-through with carry_in.
    assert_lsl_zero_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_mode && shift_kind == 2'd0 && zero_amt)
        |=> (shifted_out == $past(src_val) && carry_out == $past(carry_in)));

    // R6: zero instruction-field rotate rotates one bit through carry.
    assert_rrx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_mode && !amt_from_reg && shift_kind == 2'd3 && imm_amt == '0)
        |=> (carry_out == $past(src_val[0]) &&
             shifted_out[MSB-1:0] == $past(src_val[MSB:1]) &&
             shifted_out[MSB] == $past(carry_in)));

    // R8: arithmetic right by DATA_W or more saturates to the sign.
    assert_asr_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_mode && amt_from_reg && shift_kind == 2'd2 &&
         ramt >= REG_AMT_W'(DATA_W))
        |=> (carry_out == $past(src_val[MSB]) &&
             shifted_out == {DATA_W{$past(src_val[MSB])}}));

    // R9: logical shifts beyond DATA_W clear value and carry.
    assert_logical_over_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_mode && amt_from_reg && shift_kind[1] == 1'b0 &&
         ramt > REG_AMT_W'(DATA_W))
        |=> (shifted_out == '0 && !carry_out));

    // R3: rotate by a nonzero multiple of DATA_W leaves the value intact.
    assert_ror_full_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_mode && amt_from_reg && shift_kind == 2'd3 &&
         ramt[RW-1:0] == '0 && ramt[REG_AMT_W-1:RW] != '0)
        |=> (shifted_out == $past(src_val) && carry_out == $past(src_val[MSB])));
endmodule

bind opsh_top opsh_checker #(
    .DATA_W(DATA_W), .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .imm_mode    (imm_mode),
    .src_val     (src_val),
    .shift_kind  (shift_kind),
    .amt_from_reg(amt_from_reg),
    .imm_amt     (imm_amt),
    .reg_amt     (reg_amt),
    .carry_in    (carry_in),
    .shifted_out (shifted_out),
    .carry_out   (carry_out)
);

// File: tb/opsh_top_tb_top.sv
// Bench: behavioural one-bit-per-step reference, compared every clock.
module opsh_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imm_mode = 1'b0;
    logic [31:0] src_val = 32'hDEAD_BEEF;
    logic [1:0]  shift_kind = 2'd1;
    logic        amt_from_reg = 1'b0;
    logic [4:0]  imm_amt = 5'd3;
    logic [31:0] reg_amt = 32'd0;
    logic        carry_in = 1'b1;
    logic [7:0]  imm8 = 8'h00;
    logic [3:0]  rot4 = 4'h0;
    logic [31:0] shifted_out;
    logic        carry_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_res_q[$];
    logic        exp_c_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    opsh_top dut_i (
        .clk(clk), .rst_n(rst_n), .imm_mode(imm_mode), .src_val(src_val),
        .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
        .imm_amt(imm_amt), .reg_amt(reg_amt), .carry_in(carry_in),
        .imm8(imm8), .rot4(rot4), .shifted_out(shifted_out),
        .carry_out(carry_out)
    );

    task automatic model(input bit im, input logic [31:0] v, input logic [1:0] k,
                         input bit fr, input logic [4:0] ia, input logic [31:0] ra,
                         input bit ci, input logic [7:0] i8, input logic [3:0] r4,
                         output logic [31:0] r, output logic c);
        int n;
        r = v;
        c = ci;
        if (im) begin
            r = {24'd0, i8};
            for (int s = 0; s < 2 * r4; s++) r = {r[0], r[31:1]};
            c = (r4 == 0) ? ci : r[31];
        end else begin
            n = fr ? int'(ra[7:0]) : int'(ia);
            if (n == 0) begin
                if (k == 2'd1) c = v[31];
                else if (k == 2'd3 && !fr) begin
                    c = v[0];
                    r = {ci, v[31:1]};
                end
            end else begin
                for (int s = 0; s < n; s++) begin
                    case (k)
                        2'd0: begin c = r[31]; r = r << 1; end
                        2'd1: begin c = r[0]; r = r >> 1; end
                        2'd2: begin c = r[0]; r = {r[31], r[31:1]}; end
                        default: begin c = r[0]; r = {r[0], r[31:1]}; end
                    endcase
                end
            end
        end
    endtask

    task automatic compare_head();
        logic [31:0] er;
        logic        ec;
        string       t;
        if (exp_res_q.size() == 0) return;
        er = exp_res_q.pop_front();
        ec = exp_c_q.pop_front();
        t  = tag_q.pop_front();
        n_vec++;
        if (shifted_out !== er || carry_out !== ec) begin
            n_bad++;
            $display("FAIL %s: got res=%h c=%b, expected res=%h c=%b",
                     t, shifted_out, carry_out, er, ec);
        end
    endtask

    task automatic vec(input bit im, input logic [31:0] v, input logic [1:0] k,
                       input bit fr, input logic [4:0] ia, input logic [31:0] ra,
                       input bit ci, input logic [7:0] i8, input logic [3:0] r4,
                       input string t);
        logic [31:0] er;
        logic        ec;
        @(negedge clk);
        compare_head();
        imm_mode = im; src_val = v; shift_kind = k; amt_from_reg = fr;
        imm_amt = ia; reg_amt = ra; carry_in = ci; imm8 = i8; rot4 = r4;
        model(im, v, k, fr, ia, ra, ci, i8, r4, er, ec);
        exp_res_q.push_back(er);
        exp_c_q.push_back(ec);
        tag_q.push_back(t);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;   // R12: reset clears outputs
        if (shifted_out !== 32'd0 || carry_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R12: got res=%h c=%b, expected res=0 c=0",
                     shifted_out, carry_out);
        end
        rst_n = 1'b1;
        // R1 shift left nonzero
        vec(0, 32'h8000_0001, 2'd0, 0, 5'd1, 0, 0, 0, 0, "R1");
        vec(0, 32'h0000_0003, 2'd0, 0, 5'd31, 0, 0, 0, 0, "R1");
        // R2 logical and arithmetic right
        vec(0, 32'h8000_0010, 2'd1, 0, 5'd5, 0, 0, 0, 0, "R2");
        vec(0, 32'h8000_0010, 2'd2, 0, 5'd4, 0, 0, 0, 0, "R2");
        vec(0, 32'hC000_0000, 2'd2, 1, 5'd0, 32'd31, 0, 0, 0, "R2");
        // R3 rotate
        vec(0, 32'h1234_5678, 2'd3, 0, 5'd8, 0, 0, 0, 0, "R3");
        vec(0, 32'h8765_4321, 2'd3, 1, 5'd0, 32'd32, 0, 0, 0, "R3");
        vec(0, 32'h0000_0081, 2'd3, 1, 5'd0, 32'd65, 0, 0, 0, "R3");
        // R4 zero amount left and arithmetic right
        vec(0, 32'hF0F0_0F0F, 2'd0, 0, 5'd0, 0, 1, 0, 0, "R4");
        vec(0, 32'h8000_0000, 2'd2, 1, 5'd9, 32'h100, 0, 0, 0, "R4");
        // R5 zero amount logical right
        vec(0, 32'h8000_0000, 2'd1, 0, 5'd0, 0, 0, 0, 0, "R5");
        vec(0, 32'h7FFF_FFFF, 2'd1, 0, 5'd0, 0, 1, 0, 0, "R5");
        // R6 zero instruction-field rotate through carry
        vec(0, 32'h0000_0003, 2'd3, 0, 5'd0, 32'd7, 1, 0, 0, "R6");
        vec(0, 32'h8000_0002, 2'd3, 0, 5'd0, 0, 0, 0, 0, "R6");
        // R7 zero register rotate
        vec(0, 32'h0000_0001, 2'd3, 1, 5'd4, 32'h0, 0, 0, 0, "R7");
        // R8 arithmetic saturation
        vec(0, 32'h8000_1234, 2'd2, 1, 5'd0, 32'd32, 0, 0, 0, "R8");
        vec(0, 32'h7000_1234, 2'd2, 1, 5'd0, 32'd200, 1, 0, 0, "R8");
        // R9 logical at and beyond 32
        vec(0, 32'h0000_0001, 2'd0, 1, 5'd0, 32'd32, 0, 0, 0, "R9");
        vec(0, 32'h8000_0000, 2'd1, 1, 5'd0, 32'd32, 0, 0, 0, "R9");
        vec(0, 32'hFFFF_FFFF, 2'd0, 1, 5'd0, 32'd33, 1, 0, 0, "R9");
        vec(0, 32'hFFFF_FFFF, 2'd1, 1, 5'd0, 32'd255, 1, 0, 0, "R9");
        // R10 only low byte of register amount; reg_amt ignored for field
        vec(0, 32'h0000_00F0, 2'd1, 1, 5'd0, 32'hFFFF_FF04, 0, 0, 0, "R10");
        vec(0, 32'h0000_00F0, 2'd1, 0, 5'd2, 32'hFFFF_FF10, 0, 0, 0, "R10");
        // R11 constant expansion
        vec(1, 32'hFFFF_FFFF, 2'd2, 1, 5'd7, 32'd40, 1, 8'hAB, 4'h0, "R11");
        vec(1, 32'h0, 2'd0, 0, 5'd3, 0, 0, 8'h3F, 4'h1, "R11");
        vec(1, 32'h0, 2'd3, 0, 5'd0, 0, 1, 8'h01, 4'hF, "R11");
        vec(1, 32'h0, 2'd1, 0, 5'd0, 0, 1, 8'h80, 4'h4, "R11");
        // random sweep across all modes
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            logic [31:0] ra;
            bit          im;
            bit          fr;
            logic [1:0]  k;
            rv = $urandom;
            ra = $urandom;
            if (i % 3 == 0) ra[7:0] = 8'($urandom_range(0, 40));
            im = ($urandom_range(0, 5) == 0);
            fr = $urandom_range(0, 1) == 1;
            k  = 2'($urandom_range(0, 3));
            vec(im, rv, k, fr, 5'($urandom), ra, 1'($urandom), 8'($urandom),
                4'($urandom), im ? "R11 random" : "R1 R2 R3 random");
        end
        @(negedge clk);
        compare_head();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            finish_run();
        end
    end
endmodule